// File: doc/BRIEF.md
# Three-level control pulse decoder

This block decodes trim commands sent over a single control pin that can rest at three levels: a middle rest level, a low level and a high level. There is also an over-voltage level above the high one. An analog front end outside the block turns the pin into three comparator flags: below the low threshold, above the high threshold, and above the programming threshold. The decoder passes these flags through a synchroniser. It then measures how long each excursion away from the middle level lasts and how long the pin stayed at the middle level before that excursion.

A low excursion that is held long enough and then returns to the middle level produces a one-cycle up strobe. A high excursion of the same kind produces a one-cycle down strobe. Both strobes are gated by a count-enable input and drive an external trim counter. The first pulse that qualifies after reset is consumed silently, because the comparators come up in an unknown state.

Holding the pin at the programming level long enough produces a single store strobe, and that excursion is never also counted as a down step. Every duration is a parameter counted in clock cycles.

Top module: `ctl_pulse_decoder`

## Requirements
- R1: A low excursion (lo_flag=1, hi_flag=0) lasting more than MIN_W consecutive cycles, followed by a return to middle (both flags 0), produces exactly one one-cycle inc_stb. The strobe is high in the third clock cycle after the first middle-level sample, because the path has two synchroniser stages and one output register.
- R2: A high excursion (hi_flag=1, lo_flag=0, prog_flag=0) that meets the same width rule produces exactly one dec_stb, with the same timing as R1.
- R3: An excursion lasting MIN_W cycles or fewer produces no strobe. The band between the reject width and the minimum width is rejected.
- R4: An excursion produces a strobe only if the pin sat at the middle level for at least GAP_W consecutive cycles immediately before it. An excursion that starts sooner is discarded entirely.
- R5: After reset, the first up or down pulse that meets R1 to R4 produces no strobe. This holds whether cnt_en is high or low at that moment. Later pulses are not affected.
- R6: prog_flag held for PROG_W+1 consecutive cycles produces exactly one one-cycle prog_stb, however long it is held. A hold of PROG_W cycles produces none.
- R7: inc_stb and dec_stb are produced only if cnt_en is high in the cycle the return to middle is decoded. Otherwise the pulse is dropped.
- R8: A high excursion during which prog_flag was seen never produces dec_stb.
- R9: A qualified pulse yields one strobe no matter how long it is held; the strobe fires on the return to middle.
- R10: An excursion that passes directly between low and high, or that shows both flags at once, produces no strobe. Decoding resumes once the pin is back at the middle level and a fresh gap has been seen.
- R11: inc_stb and dec_stb are never high in the same cycle.
- R12: While rst_n is low, all three strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lo_flag | input | 1 | Comparator flag: pin below the low threshold (asynchronous) |
| hi_flag | input | 1 | Comparator flag: pin above the high threshold (asynchronous) |
| prog_flag | input | 1 | Comparator flag: pin above the programming threshold (asynchronous) |
| cnt_en | input | 1 | Count enable for up and down strobes |
| inc_stb | output | 1 | One-cycle up-count strobe |
| dec_stb | output | 1 | One-cycle down-count strobe |
| prog_stb | output | 1 | One-cycle store strobe |

## Verification
Low and high excursions are driven with widths well below, exactly at, one above and far beyond the minimum width. This separates the rejection band from acceptance and shows that a long hold still counts once. Pairs of pulses with a middle gap of two cycles and of exactly GAP_W cycles separate the re-arming rule from width qualification. Programming holds of PROG_W and PROG_W+1 cycles, a direct low-to-high swing, and pulses with count-enable low show apart the store path, the abort path and the enable gate. Two reset sequences, one with enable high and one with enable low on the first pulse, show that the first-pulse discard is independent of enable.

// File: rtl/ctl_pulse_pkg.sv
package ctl_pulse_pkg;

  // Number of synchroniser flops between the comparator flags and the decoder.
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    LV_MID  = 2'd0,
    LV_LOW  = 2'd1,
    LV_HIGH = 2'd2,
    LV_BAD  = 2'd3
  } pin_level_e;

  typedef enum logic [1:0] {
    ST_REST = 2'd0,   // at middle level, measuring the gap
    ST_DOWN = 2'd1,   // inside a low excursion
    ST_UP   = 2'd2,   // inside a high excursion
    ST_VOID = 2'd3    // excursion discarded, waiting for middle
  } dec_state_e;

  function automatic pin_level_e classify(input logic lo, input logic hi);
    unique case ({hi, lo})
      2'b00:   return LV_MID;
      2'b01:   return LV_LOW;
      2'b10:   return LV_HIGH;
      default: return LV_BAD;
    endcase
  endfunction

endpackage

// File: rtl/ctl_flag_sync.sv
module ctl_flag_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ctl_run_counter.sv
module ctl_run_counter #(
  parameter int MAX_VAL = 1,
  parameter int CW      = $clog2(MAX_VAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] TOP = CW'(MAX_VAL);

  logic [CW-1:0] cnt_n;
  logic          cnt_upd;

  assign cnt_upd = clr | inc;

  always_comb begin
    cnt_n = count;
    if (clr)                     cnt_n = '0;
    else if (inc && count != TOP) cnt_n = count + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (cnt_upd) count <= cnt_n;
  end

endmodule

// File: rtl/ctl_pulse_decoder.sv
module ctl_pulse_decoder
  import ctl_pulse_pkg::*;
#(
  parameter int MIN_W  = 20,  // excursion must last more than this many cycles
  parameter int GAP_W  = 4,   // middle cycles required before an excursion (>= 1)
  parameter int PROG_W = 24   // programming hold must last more than this
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_flag,
  input  logic hi_flag,
  input  logic prog_flag,
  input  logic cnt_en,
  output logic inc_stb,
  output logic dec_stb,
  output logic prog_stb
);

  localparam int WCW = $clog2(MIN_W + 2);
  localparam int GCW = $clog2(GAP_W + 1);
  localparam int PCW = $clog2(PROG_W + 2);
  localparam logic [WCW-1:0] W_LONG = WCW'(MIN_W + 1);
  localparam logic [GCW-1:0] G_FULL = GCW'(GAP_W);
  localparam logic [PCW-1:0] P_FIRE = PCW'(PROG_W);

  // Synchronised comparator flags
  logic [2:0] raw_flags, syn_flags;
  logic       s_lo, s_hi, s_pg;

  assign raw_flags = {prog_flag, hi_flag, lo_flag};

  ctl_flag_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_flags),
    .q     (syn_flags)
  );

  assign s_lo = syn_flags[0];
  assign s_hi = syn_flags[1];
  assign s_pg = syn_flags[2];

  pin_level_e lvl;
  logic       at_mid;

  assign lvl    = classify(s_lo, s_hi);
  assign at_mid = (lvl == LV_MID);

  // Run-length measurement of excursion, gap and programming hold
  logic [WCW-1:0] wid_cnt;
  logic [GCW-1:0] gap_cnt;
  logic [PCW-1:0] pg_cnt;

  ctl_run_counter #(.MAX_VAL(MIN_W + 1), .CW(WCW)) u_wid (
    .clk(clk), .rst_n(rst_n), .clr(at_mid), .inc(!at_mid), .count(wid_cnt)
  );

  ctl_run_counter #(.MAX_VAL(GAP_W), .CW(GCW)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(!at_mid), .inc(at_mid), .count(gap_cnt)
  );

  ctl_run_counter #(.MAX_VAL(PROG_W + 1), .CW(PCW)) u_pg (
    .clk(clk), .rst_n(rst_n), .clr(!s_pg), .inc(s_pg), .count(pg_cnt)
  );

  logic armed, long_ok;
  assign armed   = (gap_cnt == G_FULL);
  assign long_ok = (wid_cnt == W_LONG);

  // Pulse state machine
  dec_state_e state_q, state_n;
  logic       first_q, first_n;
  logic       inc_q, inc_n, dec_q, dec_n, prog_q, prog_n;
  logic       qual, qual_up;

  always_comb begin
    state_n = state_q;
    qual    = 1'b0;
    qual_up = 1'b0;
    unique case (state_q)
      ST_REST: begin
        unique case (lvl)
          LV_LOW:  state_n = armed ? ST_DOWN : ST_VOID;
          LV_HIGH: state_n = (armed && !s_pg) ? ST_UP : ST_VOID;
          LV_BAD:  state_n = ST_VOID;
          default: state_n = ST_REST;
        endcase
      end
      ST_DOWN: begin
        if (at_mid) begin
          state_n = ST_REST;
          qual    = long_ok;
          qual_up = 1'b1;
        end else if (lvl != LV_LOW) begin
          state_n = ST_VOID;
        end
      end
      ST_UP: begin
        if (at_mid) begin
          state_n = ST_REST;
          qual    = long_ok;
        end else if (lvl != LV_HIGH || s_pg) begin
          state_n = ST_VOID;
        end
      end
      default: begin
        if (at_mid) state_n = ST_REST;
      end
    endcase
  end

  always_comb begin
    first_n = first_q;
    inc_n   = 1'b0;
    dec_n   = 1'b0;
    if (qual) begin
      if (!first_q) begin
        first_n = 1'b1;
      end else if (cnt_en) begin
        inc_n = qual_up;
        dec_n = !qual_up;
      end
    end
    prog_n = s_pg && (pg_cnt == P_FIRE);
  end

  logic first_upd;
  assign first_upd = qual & ~first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_REST;
      inc_q   <= 1'b0;
      dec_q   <= 1'b0;
      prog_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      inc_q   <= inc_n;
      dec_q   <= dec_n;
      prog_q  <= prog_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         first_q <= 1'b0;
    else if (first_upd) first_q <= first_n;
  end

  assign inc_stb  = inc_q;
  assign dec_stb  = dec_q;
  assign prog_stb = prog_q;

endmodule

// File: rtl/ctl_pulse_decoder_chk.sv
module ctl_pulse_decoder_chk
  import ctl_pulse_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic lo_flag,
  input logic hi_flag,
  input logic prog_flag,
  input logic cnt_en,
  input logic inc_stb,
  input logic dec_stb,
  input logic prog_stb
);

  localparam int LAT = SYNC_DEPTH + 1;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_stb && dec_stb));

  // R9
  inc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_stb |=> !inc_stb);

  // R9
  dec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |=> !dec_stb);

  // R6
  prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> !prog_stb);

  // R6
  prog_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> ($past(prog_flag, LAT) && $past(prog_flag, LAT + 1)));

  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_stb || dec_stb) |-> $past(cnt_en));

  // R1
  inc_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_stb |-> (!$past(lo_flag, LAT) && $past(lo_flag, LAT + 1)));

  // R2
  dec_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |-> (!$past(hi_flag, LAT) && $past(hi_flag, LAT + 1)));

  // R8
  dec_not_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |-> !$past(prog_flag, LAT + 1));

  // R12
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!inc_stb && !dec_stb && !prog_stb);
    end
  end

endmodule

bind ctl_pulse_decoder ctl_pulse_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lo_flag   (lo_flag),
  .hi_flag   (hi_flag),
  .prog_flag (prog_flag),
  .cnt_en    (cnt_en),
  .inc_stb   (inc_stb),
  .dec_stb   (dec_stb),
  .prog_stb  (prog_stb)
);

// File: tb/test_ctl_pulse_decoder.sv
`timescale 1ns/1ps
module test_ctl_pulse_decoder;

  localparam int MIN_W  = 20;
  localparam int GAP_W  = 4;
  localparam int PROG_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_flag = 1'b0, hi_flag = 1'b0, prog_flag = 1'b0, cnt_en = 1'b0;
  logic inc_stb, dec_stb, prog_stb;

  always #4 clk = ~clk;

  ctl_pulse_decoder #(.MIN_W(MIN_W), .GAP_W(GAP_W), .PROG_W(PROG_W)) i_ctl_pulse_decoder (
    .clk(clk), .rst_n(rst_n), .lo_flag(lo_flag), .hi_flag(hi_flag),
    .prog_flag(prog_flag), .cnt_en(cnt_en),
    .inc_stb(inc_stb), .dec_stb(dec_stb), .prog_stb(prog_stb)
  );

  int  checks = 0, fails = 0;
  int  n_inc = 0, n_dec = 0, n_prog = 0;
  bit  run_done = 0;

  // Behavioural reference: delayed pin history plus run lengths
  logic [2:0] hist [$] = '{3'b000, 3'b000};
  int  midrun = 0, nonrun = 0, pgrun = 0;
  int  mode = 0;            // 0 rest, 1 low, 2 high, 3 discarded
  bit  seen_first = 0;
  logic e_inc = 0, e_dec = 0, e_prog = 0;

  always @(posedge clk or negedge rst_n) begin : ref_model
    logic [2:0] c;
    bit mid, lo_only, hi_only, armed, longp, hit, up;
    if (!rst_n) begin
      hist = '{3'b000, 3'b000};
      midrun = 0; nonrun = 0; pgrun = 0; mode = 0; seen_first = 0;
      e_inc = 0; e_dec = 0; e_prog = 0;
    end else begin
      hist.push_back({prog_flag, hi_flag, lo_flag});
      c = hist.pop_front();
      mid     = !c[0] && !c[1];
      lo_only = c[0] && !c[1];
      hi_only = c[1] && !c[0];
      armed   = midrun >= GAP_W;
      longp   = nonrun > MIN_W;
      hit = 0; up = 0;
      case (mode)
        0: if (lo_only) mode = armed ? 1 : 3;
           else if (hi_only) mode = (armed && !c[2]) ? 2 : 3;
           else if (!mid) mode = 3;
        1: if (mid) begin mode = 0; hit = longp; up = 1; end
           else if (!lo_only) mode = 3;
        2: if (mid) begin mode = 0; hit = longp; end
           else if (!hi_only || c[2]) mode = 3;
        default: if (mid) mode = 0;
      endcase
      e_inc = 0; e_dec = 0;
      if (hit) begin
        if (!seen_first) seen_first = 1;
        else if (cnt_en) begin e_inc = up; e_dec = !up; end
      end
      e_prog = c[2] && (pgrun == PROG_W);
      midrun = mid  ? midrun + 1 : 0;
      nonrun = !mid ? nonrun + 1 : 0;
      pgrun  = c[2] ? pgrun + 1 : 0;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!run_done) begin
      checks++;
      if ({inc_stb, dec_stb, prog_stb} !== {e_inc, e_dec, e_prog} || (inc_stb && dec_stb)) begin
        fails++;
        $display("FAIL R1 R2 R6 R11 cycle compare at %0t: got %b expected %b",
                 $time, {inc_stb, dec_stb, prog_stb}, {e_inc, e_dec, e_prog});
      end
      n_inc  += int'(inc_stb === 1'b1);
      n_dec  += int'(dec_stb === 1'b1);
      n_prog += int'(prog_stb === 1'b1);
    end
  end

  task automatic check_val(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clear_counts();
    n_inc = 0; n_dec = 0; n_prog = 0;
  endtask

  task automatic excursion(input bit lo, input bit hi, input bit pg, input int len, input int gap);
    lo_flag = lo; hi_flag = hi; prog_flag = pg;
    repeat (len) @(negedge clk);
    lo_flag = 0; hi_flag = 0; prog_flag = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; lo_flag = 0; hi_flag = 0; prog_flag = 0;
    repeat (3) @(negedge clk);
    check_val("R12 inc_stb in reset", int'(inc_stb), 0);
    check_val("R12 dec_stb in reset", int'(dec_stb), 0);
    check_val("R12 prog_stb in reset", int'(prog_stb), 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    run_done = 1;
    summary();
  end

  initial begin
    @(negedge clk);
    cnt_en = 1;
    do_reset();

    // R5: first qualified pulse consumed
    clear_counts(); excursion(1, 0, 0, 30, 10);
    check_val("R5 first pulse inc", n_inc, 0);

    // R1: low pulse counts up
    clear_counts(); excursion(1, 0, 0, 30, 10);
    check_val("R1 low pulse inc", n_inc, 1);
    check_val("R1 low pulse dec", n_dec, 0);

    // R2: high pulse counts down
    clear_counts(); excursion(0, 1, 0, 30, 10);
    check_val("R2 high pulse dec", n_dec, 1);
    check_val("R2 high pulse inc", n_inc, 0);

    // R9: long hold gives one count
    clear_counts(); excursion(1, 0, 0, 200, 10);
    check_val("R9 long hold inc", n_inc, 1);

    // R3: short and boundary widths
    clear_counts(); excursion(1, 0, 0, 3, 10); excursion(1, 0, 0, MIN_W, 10);
    check_val("R3 short pulses inc", n_inc, 0);
    clear_counts(); excursion(1, 0, 0, MIN_W + 1, 10);
    check_val("R3 width MIN_W+1 inc", n_inc, 1);

    // R4: gap before an excursion
    clear_counts(); excursion(1, 0, 0, 30, 2); excursion(1, 0, 0, 30, 10);
    check_val("R4 gap 2 inc", n_inc, 1);
    clear_counts(); excursion(1, 0, 0, 30, GAP_W); excursion(1, 0, 0, 30, 10);
    check_val("R4 gap GAP_W inc", n_inc, 2);

    // R7: enable low blocks counting
    cnt_en = 0;
    clear_counts(); excursion(1, 0, 0, 30, 10); excursion(0, 1, 0, 30, 10);
    check_val("R7 disabled inc+dec", n_inc + n_dec, 0);
    cnt_en = 1;

    // R6 / R8: programming holds
    clear_counts(); excursion(0, 1, 1, 40, 10);
    check_val("R6 hold 40 prog", n_prog, 1);
    check_val("R8 hold 40 dec", n_dec, 0);
    clear_counts(); excursion(0, 1, 1, PROG_W, 10);
    check_val("R6 hold PROG_W prog", n_prog, 0);
    clear_counts(); excursion(0, 1, 1, PROG_W + 1, 10);
    check_val("R6 hold PROG_W+1 prog", n_prog, 1);

    // R10: direct low-to-high swing is dropped, then decoding resumes
    clear_counts();
    lo_flag = 1; repeat (30) @(negedge clk);
    lo_flag = 0; hi_flag = 1; repeat (30) @(negedge clk);
    hi_flag = 0; repeat (10) @(negedge clk);
    check_val("R10 swing inc+dec", n_inc + n_dec, 0);
    clear_counts(); excursion(1, 0, 0, 30, 10);
    check_val("R10 resume inc", n_inc, 1);

    // R5: discard is independent of enable
    do_reset();
    cnt_en = 0; excursion(1, 0, 0, 30, 10);
    cnt_en = 1; clear_counts(); excursion(1, 0, 0, 30, 10);
    check_val("R5 discard with enable low inc", n_inc, 1);

    run_done = 1;
    summary();
  end

endmodule